// File: doc/BRIEF.md
# Parallel Port FIFO Service Controller

This block is the buffering and service logic that sits between a host bus and the data path of an extended-capability parallel port. It holds a 16-entry, 8-bit FIFO and one extended control/status byte. The byte carries a three-bit operating mode, a mask for the fault interrupt, a DMA enable, a service-request latch, and two read-only flags that report a full or empty FIFO. The host fills the FIFO when data flows toward the peripheral (direction 0). The port side drains it, and the roles swap when the direction input is 1.

The service latch tells software or the DMA engine that the FIFO needs attention. With DMA enabled, the latch is set by the terminal-count strobe. Without DMA, it is set when the free space (forward) or the fill level (reverse) reaches a programmable threshold. Hardware only sets the latch and software only clears it. Each hardware set emits a one-cycle interrupt pulse.

A separate pulse reports a falling edge of the active-low fault line while the port is in its extended mode. A test mode lets the host write and read the FIFO back with the port side cut off. A configuration mode opens a two-byte window for configuration registers that live outside this block.

Top module: `ppfifo_svc`

## Requirements
- R1: After reset the control byte at offset 0x002 reads 0x05: mode 000, fault mask 0, DMA enable 0, service latch 1, full 0, empty 1. No pulse outputs are active and dma_req is low.
- R2: Control bit 1 reads 1 exactly when the FIFO holds 16 bytes. Control bit 0 reads 1 exactly when it holds none.
- R3: The FIFO returns bytes in the order they were written. A push into a full FIFO and a pop from an empty FIFO are ignored.
- R4: In mode 110 the port-side push and pop are ignored, port_valid and port_space are low, and the host can both write and read the FIFO through offset 0x000.
- R5: cfg_sel is high only for a bus access to offset 0x400 or 0x401 while the mode is 111.
- R6: With control bit 4 at 0 and mode 011, a high-to-low transition of fault_n gives a one-cycle fault_irq in the following cycle. With bit 4 at 1, or in any other mode, no pulse is produced.
- R7: A control write that changes bit 4 from 1 to 0, with mode 011, while fault_n is already low produces one fault_irq pulse.
- R8: dma_req is high only when DMA enable (bit 3) is 1 and the service latch (bit 2) is 0. The FIFO must also be not full in direction 0, or not empty in direction 1.
- R9: With DMA enabled and the latch clear, a dma_tc strobe sets the service latch.
- R10: With DMA disabled and direction 0, the latch is set when the free byte count is at least wr_thr.
- R11: With DMA disabled and direction 1, the latch is set when the stored byte count is at least rd_thr.
- R12: svc_irq is a one-cycle pulse issued in the cycle the hardware sets the latch. A software write of 1 to bit 2 never pulses it. The latch stays set until software writes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 11 | Host byte offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (FIFO head or control byte) |
| cfg_sel | output | 1 | Configuration register window select |
| dir | input | 1 | Transfer direction, 0 host to port, 1 port to host |
| wr_thr | input | 4 | Free-space threshold for forward service |
| rd_thr | input | 4 | Fill threshold for reverse service |
| dma_tc | input | 1 | DMA terminal-count strobe |
| dma_req | output | 1 | DMA request |
| svc_irq | output | 1 | Service interrupt pulse |
| fault_n | input | 1 | Active-low fault line, synchronous to clk |
| fault_irq | output | 1 | Fault interrupt pulse |
| port_push | input | 1 | Port side writes a byte (direction 1) |
| port_din | input | 8 | Port side write data |
| port_space | output | 1 | Port side may push |
| port_pop | input | 1 | Port side takes the head byte (direction 0) |
| port_dout | output | 8 | FIFO head byte toward the port |
| port_valid | output | 1 | Port side may pop |

## Verification
The assertions assume that fault_n and dma_tc are already synchronous to clk and stable around the edge. They also assume a bus access lasts exactly one cycle, so a FIFO read pops a single byte. The bench changes every input at the falling clock edge, raises bus_cs for a single cycle per access, and pulses dma_tc for one cycle. It drives port_push only in direction 1 and port_pop only in direction 0, except where R4 calls for ignored port traffic.

// File: rtl/ppfifo_svc.sv
module ppfifo_svc #(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int AW       = 11,
  parameter int THR_W    = 4,
  parameter logic [AW-1:0] DATA_OFS = 11'h000,
  parameter logic [AW-1:0] CTRL_OFS = 11'h002,
  parameter logic [AW-1:0] CFG_OFS  = 11'h400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             cfg_sel,
  input  logic             dir,
  input  logic [THR_W-1:0] wr_thr,
  input  logic [THR_W-1:0] rd_thr,
  input  logic             dma_tc,
  output logic             dma_req,
  output logic             svc_irq,
  input  logic             fault_n,
  output logic             fault_irq,
  input  logic             port_push,
  input  logic [DW-1:0]    port_din,
  output logic             port_space,
  input  logic             port_pop,
  output logic [DW-1:0]    port_dout,
  output logic             port_valid
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
  localparam logic [2:0] M_ECP  = 3'b011;
  localparam logic [2:0] M_TEST = 3'b110;
  localparam logic [2:0] M_CFG  = 3'b111;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [2:0]    mode;
  logic          fmask, dma_en, svc;
  logic          fault_q, svc_irq_q, fault_irq_q;

  wire full   = (cnt == FULLC);
  wire empty  = (cnt == '0);
  wire test_m = (mode == M_TEST);
  wire ecp_m  = (mode == M_ECP);
  wire cfg_m  = (mode == M_CFG);

  wire hit_data = bus_cs && (bus_addr == DATA_OFS);
  wire hit_ctrl = bus_cs && (bus_addr == CTRL_OFS);
  wire ctrl_wr  = hit_ctrl && bus_we;

  wire host_push = hit_data &&  bus_we && (test_m || !dir) && !full;
  wire host_pop  = hit_data && !bus_we && (test_m ||  dir) && !empty;
  wire pp_push   = port_push &&  dir && !test_m && !full;
  wire pp_pop    = port_pop  && !dir && !test_m && !empty;
  wire push      = host_push || pp_push;
  wire pop       = host_pop  || pp_pop;
  wire [DW-1:0] din = host_push ? bus_wdata : port_din;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  wire [CW-1:0] free_n   = FULLC - cnt;
  wire          thr_hit  = dir ? (cnt >= CW'(rd_thr)) : (free_n >= CW'(wr_thr));
  wire          svc_cond = dma_en ? dma_tc : thr_hit;
  wire          hw_set   = !svc && !ctrl_wr && svc_cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= 3'b000;
      fmask     <= 1'b0;
      dma_en    <= 1'b0;
      svc       <= 1'b1;
      svc_irq_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode   <= bus_wdata[7:5];
        fmask  <= bus_wdata[4];
        dma_en <= bus_wdata[3];
        svc    <= bus_wdata[2];
      end else if (hw_set) begin
        svc <= 1'b1;
      end
      svc_irq_q <= hw_set;
    end
  end

  wire fault_edge = fault_q && !fault_n && !fmask && ecp_m;
  wire fault_unm  = ctrl_wr && fmask && !bus_wdata[4] &&
                    (bus_wdata[7:5] == M_ECP) && !fault_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q     <= 1'b1;
      fault_irq_q <= 1'b0;
    end else begin
      fault_q     <= fault_n;
      fault_irq_q <= fault_edge || fault_unm;
    end
  end

  logic [DW-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd      = '0;
    ctrl_rd[7:0] = {mode, fmask, dma_en, svc, full, empty};
  end

  logic unused_wd;
  assign unused_wd = ^bus_wdata;

  assign bus_rdata  = hit_data ? mem[rp] : (hit_ctrl ? ctrl_rd : '0);
  assign cfg_sel    = bus_cs && cfg_m && (bus_addr[AW-1:1] == CFG_OFS[AW-1:1]);
  assign dma_req    = dma_en && !svc && (dir ? !empty : !full);
  assign svc_irq    = svc_irq_q;
  assign fault_irq  = fault_irq_q;
  assign port_dout  = mem[rp];
  assign port_valid = !dir && !test_m && !empty;
  assign port_space =  dir && !test_m && !full;

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC);

  // R4
  test_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_m && !hit_data) |=> $stable(cnt));

  // R5
  cfg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> (mode == M_CFG));

  // R6
  fault_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> $past(!fault_n));

  // R8
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en && !svc));

  // R12
  svc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_irq |-> (svc && !$past(svc)));

  // R12
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(svc) && !$past(ctrl_wr)) |-> svc);

endmodule

// File: tb/tb_ppfifo_svc.sv
`timescale 1ns/1ps
module tb_ppfifo_svc;
  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_we = 0;
  logic [10:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic cfg_sel, dir = 0;
  logic [3:0] wr_thr = 4'd15, rd_thr = 4'd15;
  logic dma_tc = 0, dma_req, svc_irq, fault_n = 1, fault_irq;
  logic port_push = 0, port_space, port_pop = 0, port_valid;
  logic [7:0] port_din = '0, port_dout;
  int total = 0, bad = 0;

  ppfifo_svc dut (.*);

  always #4 clk = ~clk;

  // {dir, thr, nbytes, expected latch}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 4'd4,  5'd12, 1'b1},
    {1'b0, 4'd5,  5'd12, 1'b0},
    {1'b0, 4'd0,  5'd16, 1'b1},
    {1'b0, 4'd15, 5'd0,  1'b1},
    {1'b1, 4'd3,  5'd3,  1'b1},
    {1'b1, 4'd4,  5'd3,  1'b0},
    {1'b1, 4'd15, 5'd16, 1'b1},
    {1'b1, 4'd1,  5'd0,  1'b0}
  };

  function automatic logic [7:0] cb(input logic [2:0] m, input logic fm,
                                    input logic de, input logic sv);
    return {m, fm, de, sv, 2'b00};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_cs = 0; bus_we = 0; port_push = 0; port_pop = 0;
    dma_tc = 0; fault_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_cs = 0;
  endtask

  task automatic probe_cfg(input logic [10:0] a, input int exp);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_addr = a;
    #1 chk("R5 cfg_sel", cfg_sel, exp);
    @(negedge clk);
    bus_cs = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();
    @(negedge clk);
    rd(11'h002, d);
    chk("R1 ctrl reset", d, 8'h05);
    chk("R1 svc_irq", svc_irq, 0);
    chk("R1 fault_irq", fault_irq, 0);
    chk("R1 dma_req", dma_req, 0);

    // R10 R11 R2 threshold table
    for (int v = 0; v < 8; v++) begin
      logic vdir, vexp;
      logic [3:0] vthr;
      logic [4:0] vn;
      {vdir, vthr, vn, vexp} = VEC[v];
      dir = vdir; wr_thr = vthr; rd_thr = vthr;
      do_reset();
      wr(11'h002, cb(3'b001, 0, 0, 1));
      if (!vdir) begin
        for (int i = 0; i < int'(vn); i++) wr(11'h000, 8'(i));
      end else begin
        for (int i = 0; i < int'(vn); i++) begin
          @(negedge clk); port_push = 1; port_din = 8'(i);
        end
        @(negedge clk); port_push = 0;
      end
      wr(11'h002, cb(3'b001, 0, 0, 0));
      @(negedge clk);
      chk(vdir ? "R11 svc_irq" : "R10 svc_irq", svc_irq, vexp);
      rd(11'h002, d);
      chk(vdir ? "R11 latch" : "R10 latch", d[2], vexp);
      chk("R2 flags", d[1:0], {vn == 5'd16, vn == 5'd0});
    end

    // R3 ordering, overflow and underflow
    dir = 0; wr_thr = 15; rd_thr = 15;
    do_reset();
    wr(11'h002, cb(3'b001, 0, 0, 1));
    for (int i = 0; i < 17; i++) wr(11'h000, 8'(i * 7 + 3));
    rd(11'h002, d);
    chk("R2 full flag", d[1:0], 2'b10);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R3 order", port_dout, 8'(i * 7 + 3));
      port_pop = 1;
    end
    @(negedge clk);
    chk("R3 drained", port_valid, 0);
    @(negedge clk);
    port_pop = 0;
    rd(11'h002, d);
    chk("R2 empty flag", d[1:0], 2'b01);
    wr(11'h000, 8'h5A);
    @(negedge clk);
    chk("R3 no underflow data", port_dout, 8'h5A);
    rd(11'h002, d);
    chk("R3 no underflow count", d[1:0], 2'b00);

    // R4 test mode
    do_reset();
    wr(11'h002, cb(3'b110, 0, 0, 1));
    wr(11'h000, 8'h11); wr(11'h000, 8'h22); wr(11'h000, 8'h33);
    @(negedge clk);
    chk("R4 port_valid", port_valid, 0);
    port_pop = 1;
    repeat (2) @(negedge clk);
    port_pop = 0;
    rd(11'h000, d); chk("R4 readback 0", d, 8'h11);
    rd(11'h000, d); chk("R4 readback 1", d, 8'h22);
    rd(11'h000, d); chk("R4 readback 2", d, 8'h33);
    rd(11'h002, d); chk("R4 empty after", d[0], 1);

    // R5 configuration window
    do_reset();
    wr(11'h002, cb(3'b001, 0, 0, 1));
    probe_cfg(11'h400, 0);
    wr(11'h002, cb(3'b111, 0, 0, 1));
    probe_cfg(11'h400, 1);
    probe_cfg(11'h401, 1);
    probe_cfg(11'h402, 0);

    // R6 fault edge
    do_reset();
    wr(11'h002, cb(3'b011, 0, 0, 1));
    @(negedge clk); fault_n = 0;
    @(negedge clk); chk("R6 pulse", fault_irq, 1);
    @(negedge clk); chk("R6 one cycle", fault_irq, 0);
    fault_n = 1;
    wr(11'h002, cb(3'b011, 1, 0, 1));
    @(negedge clk); fault_n = 0;
    @(negedge clk); chk("R6 masked", fault_irq, 0);
    @(negedge clk); chk("R6 masked late", fault_irq, 0);
    // R7 unmask while low
    wr(11'h002, cb(3'b011, 0, 0, 1));
    chk("R7 unmask pulse", fault_irq, 1);
    @(negedge clk); chk("R7 one cycle", fault_irq, 0);
    fault_n = 1;
    wr(11'h002, cb(3'b001, 0, 0, 1));
    @(negedge clk); fault_n = 0;
    @(negedge clk); chk("R6 other mode", fault_irq, 0);
    @(negedge clk); fault_n = 1;

    // R8 R9 R12 DMA path
    dir = 0;
    do_reset();
    wr(11'h002, cb(3'b001, 0, 1, 0));
    chk("R8 req empty fwd", dma_req, 1);
    @(negedge clk); dma_tc = 1;
    @(negedge clk); dma_tc = 0;
    chk("R9 svc_irq on tc", svc_irq, 1);
    chk("R8 req blocked by latch", dma_req, 0);
    @(negedge clk); chk("R12 pulse width", svc_irq, 0);
    repeat (3) @(negedge clk);
    rd(11'h002, d); chk("R12 latch holds", d[2], 1);
    wr(11'h002, cb(3'b001, 0, 1, 0));
    wr(11'h002, cb(3'b001, 0, 1, 1));
    chk("R12 sw set no pulse", svc_irq, 0);
    @(negedge clk); chk("R12 sw set no pulse later", svc_irq, 0);
    wr(11'h002, cb(3'b001, 0, 1, 0));
    for (int i = 0; i < 16; i++) wr(11'h000, 8'(i));
    @(negedge clk);
    chk("R8 req full fwd", dma_req, 0);
    dir = 1;
    #1 chk("R8 req data rev", dma_req, 1);
    wr(11'h002, cb(3'b001, 0, 0, 1));
    chk("R8 req dma off", dma_req, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule